// File: doc/BRIEF.md
# Interprocessor Interrupt Destination Arbiter

This block decides which interrupt units of a multi-unit system receive an interprocessor interrupt. A send command names an 8-bit destination, a physical or logical addressing mode, a two-bit shorthand, a three-bit delivery mode and the index of the sending unit. Every unit reports its physical ID, its logical ID, its logical format (flat or cluster), whether it is present and whether it is enabled. The arbiter turns one command into a delivery mask with one bit per unit, registered one cycle after the command strobe.

For ordinary delivery the mask holds every present unit that the destination or the shorthand selects. For lowest-priority delivery the arbiter does not compare priorities. It walks a round-robin pointer instead. The walk starts at the unit after the last one chosen and takes the first selected unit that is also enabled. When no selected unit is enabled, it falls back to the lowest selected unit, or to unit 0 when nothing is selected. Priority comparison and the delivery of the vector itself are handled elsewhere.

Top module: `ipi_dest_arbiter`

## Requirements
- R1: With shorthand 2'b00 and physical mode (cmd_logical=0), a present unit is selected when cmd_dest equals its physical ID or when cmd_dest is 8'hFF.
- R2: With shorthand 2'b00 and logical mode, a present unit whose format code is 2'b00 (flat) is selected when the AND of its logical ID and cmd_dest is nonzero.
- R3: With shorthand 2'b00 and logical mode, a present unit whose format code is 2'b01 (cluster) is selected when bits [7:4] of its logical ID equal cmd_dest[7:4] and the AND of bits [3:0] is nonzero. A unit with format code 2'b10 or 2'b11 is never selected by logical addressing.
- R4: Shorthand 2'b01 selects only the sender, 2'b10 selects every present unit, and 2'b11 selects every present unit except the sender. The destination fields are ignored for these shorthands.
- R5: A unit whose present bit is low never appears in the mask for delivery modes other than lowest-priority.
- R6: For delivery mode 3'b001 (lowest-priority), the mask has exactly one bit. That bit is the first selected, enabled unit met when searching from the pointer plus one upward, wrapping at N_UNITS.
- R7: After reset the pointer holds N_UNITS-1, so the first lowest-priority search starts at unit 0. A successful search moves the pointer to the chosen unit.
- R8: If no selected unit is enabled, the lowest-numbered selected unit is delivered, or unit 0 when no unit is selected. The pointer does not move.
- R9: dlv_valid is high exactly in the cycle after a cycle with cmd_valid high, and dlv_mask carries that command's result. Out of reset, and in every cycle with dlv_valid low, both outputs are zero.
- R10: Commands with a delivery mode other than 3'b001 leave the round-robin pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One command per cycle in which it is high |
| cmd_dest | input | ID_W | Destination ID or logical destination bits |
| cmd_logical | input | 1 | 0 = physical addressing, 1 = logical |
| cmd_shorthand | input | 2 | 00 none, 01 self, 10 all, 11 all but sender |
| cmd_dlv_mode | input | 3 | Delivery mode; 3'b001 is lowest-priority |
| cmd_sender | input | IDX_W | Index of the sending unit |
| unit_present | input | N_UNITS | Unit exists |
| unit_enabled | input | N_UNITS | Unit is enabled for lowest-priority choice |
| unit_phys_id | input | N_UNITS*ID_W | Physical IDs, unit i at bits [i*ID_W +: ID_W] |
| unit_log_id | input | N_UNITS*ID_W | Logical IDs, same packing |
| unit_fmt | input | N_UNITS*2 | Logical format per unit: 00 flat, 01 cluster |
| dlv_valid | output | 1 | Mask valid, one cycle after cmd_valid |
| dlv_mask | output | N_UNITS | Units that receive the interrupt |

## Verification
The hardest state to reach is a lowest-priority command where units are selected but none is enabled. In that state the fallback bit must come out and the pointer must stay where it was. The stock of the pointer can only be seen through the next lowest-priority pick. The directed stimulus therefore disables all units, sends such a command, re-enables them and sends another broadcast lowest-priority command whose pick reveals the pointer. Random runs then mix formats, disabled and absent units and delivery modes against a bench model that keeps its own copy of the pointer.

// File: rtl/ipi_arb_pkg.sv
// Shared constants of the interprocessor interrupt destination arbiter.
// Assumes 8-bit style IDs split into two equal halves for cluster mode.
package ipi_arb_pkg;
    localparam logic [1:0] SH_NONE    = 2'b00;
    localparam logic [1:0] SH_SELF    = 2'b01;
    localparam logic [1:0] SH_ALL_INC = 2'b10;
    localparam logic [1:0] SH_ALL_EXC = 2'b11;

    localparam logic [1:0] FMT_FLAT    = 2'b00;
    localparam logic [1:0] FMT_CLUSTER = 2'b01;

    localparam logic [2:0] DM_LOWEST = 3'b001;
endpackage

// File: rtl/ipi_unit_match.sv
// Destination match for one unit: applies the shorthand, then physical,
// flat-logical or cluster-logical matching. Assumes ID_W is even.
module ipi_unit_match
    import ipi_arb_pkg::*;
#(
    parameter int ID_W     = 8,
    parameter int IDX_W    = 3,
    parameter int UNIT_IDX = 0
) (
    input  logic [ID_W-1:0]  dest,
    input  logic             logical,
    input  logic [1:0]       shorthand,
    input  logic [IDX_W-1:0] sender,
    input  logic             present,
    input  logic [ID_W-1:0]  phys_id,
    input  logic [ID_W-1:0]  log_id,
    input  logic [1:0]       fmt,
    output logic             hit
);
    localparam int HALF = ID_W / 2;

    logic is_self;
    logic addr_hit;

    // Purpose: decide whether this unit is the sender.
    always_comb is_self = (sender == IDX_W'(UNIT_IDX));

    // Purpose: address match when no shorthand is given.
    always_comb begin
        addr_hit = 1'b0;
        if (!logical) begin
            addr_hit = (dest == phys_id) || (dest == {ID_W{1'b1}});
        end else if (fmt == FMT_FLAT) begin
            addr_hit = |(log_id & dest);
        end else if (fmt == FMT_CLUSTER) begin
            addr_hit = (log_id[ID_W-1:HALF] == dest[ID_W-1:HALF]) &&
                       (|(log_id[HALF-1:0] & dest[HALF-1:0]));
        end
    end

    // Purpose: combine shorthand, address match and presence.
    always_comb begin
        unique case (shorthand)
            SH_NONE:    hit = present && addr_hit;
            SH_SELF:    hit = present && is_self;
            SH_ALL_INC: hit = present;
            default:    hit = present && !is_self;
        endcase
    end
endmodule

// File: rtl/ipi_rr_pick.sv
// Round-robin chooser for lowest-priority delivery. Holds the pointer to
// the last chosen unit, searches from the next unit with wrap, and falls
// back to the lowest selected unit (or unit 0) when none is enabled.
// Assumes N_UNITS >= 2.
module ipi_rr_pick #(
    parameter int N_UNITS = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               advance,
    input  logic [N_UNITS-1:0] bitmap,
    input  logic [N_UNITS-1:0] enabled,
    output logic [N_UNITS-1:0] pick_mask
);
    logic [IDX_W-1:0]   ptr_q;
    logic [N_UNITS-1:0] elig;
    logic               found;
    logic [IDX_W-1:0]   found_idx;
    logic [IDX_W-1:0]   fb_idx;
    logic [IDX_W-1:0]   pick_idx;

    // Purpose: units that may take a lowest-priority interrupt.
    always_comb elig = bitmap & enabled;

    // Purpose: first eligible unit after the pointer, with wrap.
    always_comb begin
        found     = 1'b0;
        found_idx = '0;
        for (int k = 1; k <= N_UNITS; k++) begin
            int j;
            j = (int'(ptr_q) + k) % N_UNITS;
            if (!found && elig[j]) begin
                found     = 1'b1;
                found_idx = IDX_W'(j);
            end
        end
    end

    // Purpose: fallback to the lowest selected unit, unit 0 if none.
    always_comb begin
        fb_idx = '0;
        for (int i = N_UNITS - 1; i >= 0; i--) begin
            if (bitmap[i]) fb_idx = IDX_W'(i);
        end
    end

    // Purpose: one-hot result.
    always_comb begin
        pick_idx  = found ? found_idx : fb_idx;
        pick_mask = {{(N_UNITS-1){1'b0}}, 1'b1} << pick_idx;
    end

    // Purpose: pointer starts at the last unit and follows successful picks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= IDX_W'(N_UNITS - 1);
        end else if (advance && found) begin
            ptr_q <= found_idx;
        end
    end

    // R8: failed search leaves the pointer in place
    assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !(|elig)) |=> $stable(ptr_q));

    // R7: a successful search lands the pointer on an eligible unit
    assert_ptr_eligible_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && (|elig)) |=> ((($past(elig) >> ptr_q) & N_UNITS'(1)) != '0));

    // R10: no advance, no pointer move
    assert_ptr_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(ptr_q));
endmodule

// File: rtl/ipi_dest_arbiter.sv
// Interprocessor interrupt destination arbiter. One command per cmd_valid
// cycle; the delivery mask is registered and appears one cycle later.
// Assumes N_UNITS >= 2 and an even ID_W.
module ipi_dest_arbiter
    import ipi_arb_pkg::*;
#(
    parameter int N_UNITS = 8,
    parameter int ID_W    = 8,
    parameter int IDX_W   = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [ID_W-1:0]         cmd_dest,
    input  logic                    cmd_logical,
    input  logic [1:0]              cmd_shorthand,
    input  logic [2:0]              cmd_dlv_mode,
    input  logic [IDX_W-1:0]        cmd_sender,
    input  logic [N_UNITS-1:0]      unit_present,
    input  logic [N_UNITS-1:0]      unit_enabled,
    input  logic [N_UNITS*ID_W-1:0] unit_phys_id,
    input  logic [N_UNITS*ID_W-1:0] unit_log_id,
    input  logic [N_UNITS*2-1:0]    unit_fmt,
    output logic                    dlv_valid,
    output logic [N_UNITS-1:0]      dlv_mask
);
    logic [N_UNITS-1:0] match;
    logic [N_UNITS-1:0] rr_mask;
    logic               is_lowest;

    // Purpose: one matcher per unit.
    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        ipi_unit_match #(
            .ID_W     (ID_W),
            .IDX_W    (IDX_W),
            .UNIT_IDX (u)
        ) match_i (
            .dest      (cmd_dest),
            .logical   (cmd_logical),
            .shorthand (cmd_shorthand),
            .sender    (cmd_sender),
            .present   (unit_present[u]),
            .phys_id   (unit_phys_id[u*ID_W +: ID_W]),
            .log_id    (unit_log_id[u*ID_W +: ID_W]),
            .fmt       (unit_fmt[u*2 +: 2]),
            .hit       (match[u])
        );
    end

    // Purpose: flag lowest-priority delivery.
    always_comb is_lowest = (cmd_dlv_mode == DM_LOWEST);

    ipi_rr_pick #(
        .N_UNITS (N_UNITS),
        .IDX_W   (IDX_W)
    ) rr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (cmd_valid && is_lowest),
        .bitmap    (match),
        .enabled   (unit_enabled),
        .pick_mask (rr_mask)
    );

    // Purpose: register the delivery result one cycle after the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dlv_valid <= 1'b0;
            dlv_mask  <= '0;
        end else begin
            dlv_valid <= cmd_valid;
            dlv_mask  <= cmd_valid ? (is_lowest ? rr_mask : match) : '0;
        end
    end

    // R9: valid follows the command strobe by one cycle
    assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> dlv_valid);
    assert_valid_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (!dlv_valid && dlv_mask == '0));

    // R6: lowest-priority delivery targets exactly one unit
    assert_lowest_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && is_lowest) |=> ($countones(dlv_mask) == 1));

    // R5: absent units are never targeted by ordinary delivery
    assert_absent_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !is_lowest) |=> ((dlv_mask & ~$past(unit_present)) == '0));
endmodule

// File: tb/ipi_dest_arbiter_tb.sv
module ipi_dest_arbiter_tb_top;
    localparam int N = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [7:0]       cmd_dest = '0;
    logic             cmd_logical = 1'b0;
    logic [1:0]       cmd_shorthand = '0;
    logic [2:0]       cmd_dlv_mode = '0;
    logic [2:0]       cmd_sender = '0;
    logic [N-1:0]     unit_present;
    logic [N-1:0]     unit_enabled;
    logic [N*8-1:0]   unit_phys_id;
    logic [N*8-1:0]   unit_log_id;
    logic [N*2-1:0]   unit_fmt;
    logic             dlv_valid;
    logic [N-1:0]     dlv_mask;

    logic [7:0] ids [N];
    logic [7:0] lids[N];
    logic [1:0] fmts[N];
    logic       pres[N];
    logic       ens [N];

    int n_checks = 0;
    int n_fail   = 0;
    int mptr     = N - 1;
    bit done     = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    // Pack the per-unit bench configuration onto the ports.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            unit_phys_id[i*8 +: 8] = ids[i];
            unit_log_id[i*8 +: 8]  = lids[i];
            unit_fmt[i*2 +: 2]     = fmts[i];
            unit_present[i]        = pres[i];
            unit_enabled[i]        = ens[i];
        end
    end

    ipi_dest_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_dest(cmd_dest),
        .cmd_logical(cmd_logical), .cmd_shorthand(cmd_shorthand),
        .cmd_dlv_mode(cmd_dlv_mode), .cmd_sender(cmd_sender),
        .unit_present(unit_present), .unit_enabled(unit_enabled),
        .unit_phys_id(unit_phys_id), .unit_log_id(unit_log_id),
        .unit_fmt(unit_fmt), .dlv_valid(dlv_valid), .dlv_mask(dlv_mask)
    );

    // Bench model of the requirements; returns the mask and the next pointer.
    function automatic logic [N-1:0] model(input logic [7:0] d, input logic lg,
            input logic [1:0] sh, input logic [2:0] dm, input int snd,
            input int ptr, output int nptr);
        logic [N-1:0] hit;
        logic [N-1:0] res;
        bit found;
        hit = '0;
        for (int i = 0; i < N; i++) begin
            logic a;
            if (!lg) a = (d == ids[i]) || (d == 8'hFF);
            else if (fmts[i] == 2'b00) a = |(lids[i] & d);
            else if (fmts[i] == 2'b01) a = (lids[i][7:4] == d[7:4]) && (|(lids[i][3:0] & d[3:0]));
            else a = 1'b0;
            case (sh)
                2'b00: hit[i] = a;
                2'b01: hit[i] = (i == snd);
                2'b10: hit[i] = 1'b1;
                default: hit[i] = (i != snd);
            endcase
            if (!pres[i]) hit[i] = 1'b0;
        end
        nptr = ptr;
        if (dm != 3'b001) return hit;
        found = 1'b0;
        res = '0;
        for (int k = 1; k <= N; k++) begin
            int j;
            j = (ptr + k) % N;
            if (!found && hit[j] && ens[j]) begin
                found = 1'b1;
                res = '0;
                res[j] = 1'b1;
                nptr = j;
            end
        end
        if (!found) begin
            res = 8'h01;
            for (int i = N - 1; i >= 0; i--) if (hit[i]) res = N'(1) << i;
        end
        return res;
    endfunction

    task automatic check(input bit ok, input string req, input logic [N-1:0] act,
            input logic [N-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual mask %h valid %0b, expected mask %h", req, act, dlv_valid, exp);
        end
    endtask

    // Send one command; compare to the directed value if given, else to the model.
    task automatic send(input logic [7:0] d, input logic lg, input logic [1:0] sh,
            input logic [2:0] dm, input int snd, input bit use_dir,
            input logic [N-1:0] dir, input string req);
        logic [N-1:0] exp;
        int np;
        @(negedge clk);
        cmd_dest = d; cmd_logical = lg; cmd_shorthand = sh;
        cmd_dlv_mode = dm; cmd_sender = 3'(snd); cmd_valid = 1'b1;
        exp = model(d, lg, sh, dm, snd, mptr, np);
        mptr = np;
        if (use_dir) exp = dir;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(dlv_valid && dlv_mask == exp, req, dlv_mask, exp);
    endtask

    task automatic flat_setup();
        for (int i = 0; i < N; i++) begin
            ids[i] = 8'h10 + 8'(i); lids[i] = 8'(1 << i); fmts[i] = 2'b00;
            pres[i] = 1'b1; ens[i] = 1'b1;
        end
    endtask

    initial begin
        void'($urandom(32'd20240607));
        flat_setup();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!dlv_valid && dlv_mask == '0, "R9 reset", dlv_mask, '0);

        // Physical, broadcast and absence
        send(8'h13, 0, 2'b00, 3'b000, 0, 1, 8'h08, "R1 physical exact");
        pres[5] = 1'b0;
        send(8'hFF, 0, 2'b00, 3'b000, 0, 1, 8'hDF, "R1 R5 broadcast absent");
        send(8'h15, 0, 2'b00, 3'b000, 0, 1, 8'h00, "R5 absent exact id");
        pres[5] = 1'b1;
        // Flat logical
        send(8'h05, 1, 2'b00, 3'b000, 0, 1, 8'h05, "R2 flat");
        // Cluster logical
        for (int i = 0; i < N; i++) begin
            fmts[i] = 2'b01; lids[i] = {4'(i / 2), 4'(1 << (i % 2))};
        end
        send(8'h13, 1, 2'b00, 3'b000, 0, 1, 8'h0C, "R3 cluster two");
        send(8'h12, 1, 2'b00, 3'b000, 0, 1, 8'h08, "R3 cluster one");
        fmts[2] = 2'b10;
        send(8'h13, 1, 2'b00, 3'b000, 0, 1, 8'h08, "R3 unknown format");
        // Shorthands
        flat_setup();
        send(8'h00, 0, 2'b01, 3'b000, 4, 1, 8'h10, "R4 self");
        send(8'h00, 0, 2'b10, 3'b000, 4, 1, 8'hFF, "R4 all incl");
        send(8'h00, 0, 2'b11, 3'b000, 4, 1, 8'hEF, "R4 all excl");
        pres[4] = 1'b0;
        send(8'h14, 0, 2'b01, 3'b000, 4, 1, 8'h00, "R4 R5 self absent");
        pres[4] = 1'b1;

        // Round robin
        send(8'hFF, 0, 2'b00, 3'b001, 0, 1, 8'h01, "R7 first pick unit0");
        send(8'hFF, 0, 2'b00, 3'b001, 0, 1, 8'h02, "R6 next pick");
        send(8'hFF, 0, 2'b00, 3'b001, 0, 1, 8'h04, "R6 next pick");
        send(8'hFF, 0, 2'b00, 3'b000, 0, 1, 8'hFF, "R10 fixed between");
        send(8'hFF, 0, 2'b00, 3'b001, 0, 1, 8'h08, "R10 pointer kept");
        ens[4] = 1'b0; ens[5] = 1'b0;
        send(8'hFF, 0, 2'b00, 3'b001, 0, 1, 8'h40, "R6 skip disabled");
        send(8'hFF, 0, 2'b00, 3'b001, 0, 1, 8'h80, "R6 last unit");
        send(8'hFF, 0, 2'b00, 3'b001, 0, 1, 8'h01, "R6 wrap");
        for (int i = 0; i < N; i++) ens[i] = 1'b0;
        send(8'h30, 1, 2'b00, 3'b001, 0, 1, 8'h10, "R8 fallback lowest set");
        for (int i = 0; i < N; i++) ens[i] = 1'b1;
        send(8'hFF, 0, 2'b00, 3'b001, 0, 1, 8'h02, "R8 pointer held");
        send(8'h99, 0, 2'b00, 3'b001, 0, 1, 8'h01, "R8 empty bitmap");
        send(8'hFF, 0, 2'b00, 3'b001, 0, 1, 8'h04, "R8 pointer held empty");

        // Constrained random against the model
        for (int t = 0; t < 400; t++) begin
            logic [7:0] d;
            logic [2:0] dm;
            int snd;
            for (int i = 0; i < N; i++) begin
                ids[i]  = 8'($urandom % 16);
                lids[i] = 8'($urandom);
                fmts[i] = ($urandom % 8 < 6) ? 2'($urandom % 2) : 2'($urandom % 4);
                pres[i] = ($urandom % 8) != 0;
                ens[i]  = ($urandom % 4) != 0;
            end
            snd = int'($urandom % N);
            case ($urandom % 4)
                0: d = 8'hFF;
                1: d = 8'($urandom);
                default: d = ids[$urandom % N];
            endcase
            dm = ($urandom % 2) ? 3'b001 : 3'($urandom);
            send(d, 1'($urandom), ($urandom % 3 == 0) ? 2'($urandom) : 2'b00,
                 dm, snd, 0, '0, "R1-mix random R6 R2 R3");
        end
        @(negedge clk);
        check(!dlv_valid && dlv_mask == '0, "R9 idle", dlv_mask, '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running, expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule